// File: doc/BRIEF.md
# Unaligned load assembly unit

This block sits between a load pipeline and a memory port that can only return whole, aligned 32-bit words. A load request names a byte address, an access width of one, two or four bytes, and whether the result is sign or zero extended. The block turns each request into one aligned word read when the requested bytes lie inside a single word, or two aligned word reads when they straddle a word boundary. It then shifts the fetched words into place, merges them with an OR and extends the field to a right-justified 32-bit result. Bytes are ordered little-endian.

A trap-mode input, sampled when a request is taken, makes the block refuse misaligned requests. It does not touch the bus and answers with a fault flag plus the offending byte address. One load is in flight at a time. The request side and the memory request side use valid/ready handshakes. Read data returns with a one-cycle valid strobe, and the result is presented with a one-cycle valid pulse.

The control is a state machine with states IDLE, LO_REQ, LO_WAIT, HI_REQ, HI_WAIT, RESP and FAULT. Its transitions are:
- IDLE to FAULT on a taken request that is misaligned in trap mode.
- IDLE to LO_REQ on any other taken request.
- LO_REQ to LO_WAIT on the memory handshake.
- LO_WAIT to HI_REQ when the first word arrives and the load crosses a word boundary.
- LO_WAIT to RESP when the first word arrives and the load does not cross.
- HI_REQ to HI_WAIT on the second handshake.
- HI_WAIT to RESP when the second word arrives.
- RESP to IDLE, and FAULT to IDLE, unconditionally.

Top module: `ldalign_top`

## Requirements
- R1: While reset is asserted and right after it is released, req_ready is 1, mem_req_valid is 0 and rsp_valid is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only when no load is in flight, and stays 0 from the edge that takes a request until the cycle after its response pulse.
- R3: Once mem_req_valid is raised, it and mem_addr hold steady until mem_req_ready is seen high. mem_addr carries only the word index, which is the byte address with its two low bits removed.
- R4: A load that lies inside one word causes exactly one bus read, at the word index of the request address.
- R5: A load whose last byte lies in the following word causes exactly two bus reads: first the word index of the address, then that index plus one (wrapping at the top of the address space). The result takes its low bytes from the first word and its high bytes from the second.
- R6: The size code req_size is 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. Result byte i is the memory byte at address plus i, with byte k of a word in word bits 8k+7..8k, and the result is right-justified.
- R7: For one- and two-byte loads, req_signed=1 fills the upper result bits with the field's top bit and req_signed=0 fills them with zeros. Four-byte loads ignore req_signed.
- R8: With trap_mode=1 on the edge that takes a request, a two-byte request with address bit 0 set, or a four-byte request with either of address bits 1:0 set, makes no bus read. The next cycle carries rsp_valid=1, rsp_fault=1, rsp_data=0 and rsp_fault_addr equal to the request address.
- R9: With trap_mode=1, aligned requests and all one-byte requests are served exactly as with trap_mode=0.
- R10: With trap_mode=0, a misaligned load that stays inside one word (a two-byte load at byte offset 1) is served with a single bus read.
- R11: rsp_valid is a one-cycle pulse. For a served load it rises in the cycle after the edge that captures the last needed read word, with rsp_fault=0 and rsp_fault_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Access width code (0 byte, 1 half, 2 or 3 word) |
| req_signed | input | 1 | Sign-extend the result |
| trap_mode | input | 1 | Fault misaligned requests instead of serving them |
| mem_req_valid | output | 1 | Word read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_addr | output | ADDR_W-2 | Word index of the read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | DATA_W | Read word |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | DATA_W | Right-justified, extended load result |
| rsp_fault | output | 1 | Alignment fault for this response |
| rsp_fault_addr | output | ADDR_W | Faulting byte address, zero otherwise |

## Verification
A trap-mode fault is due one cycle after the edge that takes the request. A served result is due one cycle after the edge that captures its last read word. A read request is due the cycle after the request is taken, or after the first word is captured for a crossing load. The bench drives every input on the falling edge and samples every output on the falling edge. Its reference model predicts, from what it drove at the previous falling edge, whether a response pulse must be present at the current one. It compares rsp_valid against that prediction every cycle, so an early, late or extra pulse is reported, as well as a wrong value. Bus read addresses and their number are checked at each memory handshake against the list the model derived from the request.

// File: rtl/ldalign_pkg.sv
package ldalign_pkg;

    // Access width code carried on req_size
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD3 = 2'd3
    } ld_size_e;

    // Control states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO_REQ,
        ST_LO_WAIT,
        ST_HI_REQ,
        ST_HI_WAIT,
        ST_RESP,
        ST_FAULT
    } ld_state_e;

endpackage

// File: rtl/ldalign_decode.sv
module ldalign_decode
    import ldalign_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BYTES)
) (
    input  logic [OFF_W-1:0] offset,
    input  ld_size_e         size,
    output logic             misaligned,
    output logic             crosses
);

    logic [OFF_W:0] width;
    logic [OFF_W:0] span_end;

    // Byte count of the access
    always_comb begin
        unique case (size)
            SZ_BYTE: width = (OFF_W+1)'(1);
            SZ_HALF: width = (OFF_W+1)'(2);
            default: width = (OFF_W+1)'(BYTES);
        endcase
    end

    // One past the last byte touched, relative to the word start
    assign span_end   = {1'b0, offset} + width;
    assign crosses    = span_end > (OFF_W+1)'(BYTES);
    assign misaligned = ({1'b0, offset} & (width - (OFF_W+1)'(1))) != '0;

endmodule

// File: rtl/ldalign_merge.sv
module ldalign_merge
    import ldalign_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int SH_W   = OFF_W + 4
) (
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] hi_word,
    input  logic [OFF_W-1:0]  offset,
    input  logic              crosses,
    input  ld_size_e          size,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] result
);

    logic [SH_W-1:0]   lo_shift;
    logic [SH_W-1:0]   hi_shift;
    logic [DATA_W-1:0] lo_part;
    logic [DATA_W-1:0] hi_part;
    logic [DATA_W-1:0] merged;

    // Lower word moves down by the byte offset; upper word moves up by the rest
    assign lo_shift = SH_W'({offset, 3'b000});
    assign hi_shift = SH_W'(DATA_W) - lo_shift;
    assign lo_part  = lo_word >> lo_shift;
    assign hi_part  = crosses ? (hi_word << hi_shift) : '0;
    assign merged   = lo_part | hi_part;

    // Width trim and extension
    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){sign_ext & merged[7]}}, merged[7:0]};
            SZ_HALF: result = {{(DATA_W-16){sign_ext & merged[15]}}, merged[15:0]};
            default: result = merged;
        endcase
    end

endmodule

// File: rtl/ldalign_ctrl.sv
module ldalign_ctrl
    import ldalign_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic trap_mode,
    input  logic misal_in,
    input  logic cross_q,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    output logic req_ready,
    output logic accept,
    output logic mem_req_valid,
    output logic sel_hi,
    output logic cap_lo,
    output logic cap_hi,
    output logic rsp_valid,
    output logic rsp_fault
);

    ld_state_e state_q;
    ld_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (trap_mode && misal_in) ? ST_FAULT : ST_LO_REQ;
                end
            end
            ST_LO_REQ: begin
                if (mem_req_ready) state_d = ST_LO_WAIT;
            end
            ST_LO_WAIT: begin
                if (mem_rsp_valid) state_d = cross_q ? ST_HI_REQ : ST_RESP;
            end
            ST_HI_REQ: begin
                if (mem_req_ready) state_d = ST_HI_WAIT;
            end
            ST_HI_WAIT: begin
                if (mem_rsp_valid) state_d = ST_RESP;
            end
            ST_RESP:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready     = 1'b0;
        accept        = 1'b0;
        mem_req_valid = 1'b0;
        sel_hi        = 1'b0;
        cap_lo        = 1'b0;
        cap_hi        = 1'b0;
        rsp_valid     = 1'b0;
        rsp_fault     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
            end
            ST_LO_REQ:  mem_req_valid = 1'b1;
            ST_LO_WAIT: cap_lo = mem_rsp_valid;
            ST_HI_REQ: begin
                mem_req_valid = 1'b1;
                sel_hi        = 1'b1;
            end
            ST_HI_WAIT: cap_hi = mem_rsp_valid;
            ST_RESP:    rsp_valid = 1'b1;
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ldalign_top.sv
module ldalign_top
    import ldalign_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int IDX_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              trap_mode,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [IDX_W-1:0]  mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_fault_addr
);

    ld_size_e          size_in;
    logic              misal_in;
    logic              cross_in;
    logic              accept;
    logic              sel_hi;
    logic              cap_lo;
    logic              cap_hi;
    logic [ADDR_W-1:0] addr_q;
    ld_size_e          size_q;
    logic              sgn_q;
    logic              cross_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] merged;
    logic [IDX_W-1:0]  idx_q;

    assign size_in = ld_size_e'(req_size);

    ldalign_decode #(.DATA_W(DATA_W)) decode_i (
        .offset     (req_addr[OFF_W-1:0]),
        .size       (size_in),
        .misaligned (misal_in),
        .crosses    (cross_in)
    );

    ldalign_ctrl ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .trap_mode     (trap_mode),
        .misal_in      (misal_in),
        .cross_q       (cross_q),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .req_ready     (req_ready),
        .accept        (accept),
        .mem_req_valid (mem_req_valid),
        .sel_hi        (sel_hi),
        .cap_lo        (cap_lo),
        .cap_hi        (cap_hi),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault)
    );

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            sgn_q   <= 1'b0;
            cross_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            size_q  <= size_in;
            sgn_q   <= req_signed;
            cross_q <= cross_in;
        end
    end

    // Read word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= mem_rsp_data;
            if (cap_hi) hi_q <= mem_rsp_data;
        end
    end

    ldalign_merge #(.DATA_W(DATA_W)) merge_i (
        .lo_word  (lo_q),
        .hi_word  (hi_q),
        .offset   (addr_q[OFF_W-1:0]),
        .crosses  (cross_q),
        .size     (size_q),
        .sign_ext (sgn_q),
        .result   (merged)
    );

    assign idx_q          = addr_q[ADDR_W-1:OFF_W];
    assign mem_addr       = sel_hi ? idx_q + IDX_W'(1) : idx_q;
    assign rsp_data       = (rsp_valid && !rsp_fault) ? merged : '0;
    assign rsp_fault_addr = rsp_fault ? addr_q : '0;

endmodule

// File: rtl/ldalign_chk.sv
module ldalign_chk #(
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 32,
    localparam int OFF_W  = $clog2(DATA_W / 8),
    localparam int IDX_W  = ADDR_W - OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              trap_mode,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [IDX_W-1:0]  mem_addr,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [ADDR_W-1:0] rsp_fault_addr
);

    logic port_misal;
    assign port_misal = ((req_size == 2'd1) && req_addr[0]) ||
                        ((req_size[1] == 1'b1) && (req_addr[OFF_W-1:0] != '0));

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)); // R3

    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R2

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready); // R11

    AST_FAULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && trap_mode && port_misal |=>
            rsp_valid && rsp_fault && !mem_req_valid && rsp_fault_addr == $past(req_addr)); // R8

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> $past(req_valid && req_ready && trap_mode)); // R8

    AST_SERVED_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !(trap_mode && port_misal) |=> !rsp_valid && mem_req_valid); // R9

endmodule

bind ldalign_top ldalign_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_size       (req_size),
    .trap_mode      (trap_mode),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_addr       (mem_addr),
    .rsp_valid      (rsp_valid),
    .rsp_fault      (rsp_fault),
    .rsp_fault_addr (rsp_fault_addr)
);

// File: tb/ldalign_top_tb_top.sv
`timescale 1ns/1ps
module ldalign_top_tb_top;

    localparam int CYC_LIMIT = 20000;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_signed;
    logic        trap_mode;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [29:0] mem_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_fault;
    logic [31:0] rsp_fault_addr;

    ldalign_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_signed(req_signed), .trap_mode(trap_mode),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
        .rsp_fault_addr(rsp_fault_addr)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    typedef struct {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        sgn;
        logic        trap;
    } req_t;

    req_t  reqs[$];
    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;

    // Reference model state
    bit          busy = 0;
    bit          rsp_due = 0;
    bit          pend = 0;
    int          pend_cnt = 0;
    logic [29:0] pend_idx;
    int          issued = 0;
    int          got = 0;
    int          exp_n = 0;
    logic [29:0] exp_idx;
    logic [31:0] exp_data;
    bit          exp_fault;
    logic [31:0] exp_faddr;
    string       exp_tag;
    bit          prev_stall = 0;
    logic [29:0] prev_addr;

    function automatic logic [31:0] mword(logic [29:0] idx);
        return ({2'b00, idx} * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [7:0] mbyte(logic [31:0] a);
        logic [31:0] w;
        w = mword(a[31:2]);
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic take(req_t r);
        int          n;
        bit          mis;
        bit          crs;
        logic [31:0] v;
        n   = (r.size == 2'd0) ? 1 : (r.size == 2'd1) ? 2 : 4;
        mis = (r.addr % n) != 0;
        crs = (int'(r.addr[1:0]) + n) > 4;
        v   = '0;
        for (int i = 0; i < n; i++) v[8*i +: 8] = mbyte(r.addr + i);
        if (r.sgn && n < 4 && v[8*n-1]) v = v | ~((32'd1 << (8*n)) - 32'd1);
        exp_fault = r.trap && mis;
        exp_faddr = exp_fault ? r.addr : 32'd0;
        exp_data  = exp_fault ? 32'd0 : v;
        exp_n     = exp_fault ? 0 : (crs ? 2 : 1);
        exp_idx   = r.addr[31:2];
        if (exp_fault)                    exp_tag = "R8";
        else if (r.trap)                  exp_tag = "R9";
        else if (crs)                     exp_tag = "R5";
        else if (mis)                     exp_tag = "R10";
        else if (r.sgn)                   exp_tag = "R7";
        else if (r.size != 2'd1)          exp_tag = "R6";
        else                              exp_tag = "R4";
        busy    = 1;
        issued  = 0;
        got     = 0;
        rsp_due = exp_fault;
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        // R2: readiness follows the in-flight state
        chk(req_ready == !busy, "R2", "req_ready", {31'd0, req_ready}, {31'd0, !busy});
        // R11: response pulse timing and content
        chk(rsp_valid == rsp_due, "R11", "rsp_valid timing", {31'd0, rsp_valid}, {31'd0, rsp_due});
        if (rsp_valid && rsp_due) begin
            chk(rsp_fault == exp_fault, exp_tag, "rsp_fault", {31'd0, rsp_fault}, {31'd0, exp_fault});
            chk(rsp_data == exp_data, exp_tag, "rsp_data", rsp_data, exp_data);
            chk(rsp_fault_addr == exp_faddr, exp_tag, "rsp_fault_addr", rsp_fault_addr, exp_faddr);
            chk(issued == exp_n, exp_tag, "bus read count", issued, exp_n);
            busy = 0;
        end
        rsp_due = 0;
        // Memory data return
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mword(pend_idx);
                pend = 0;
                got++;
                if (got == exp_n) rsp_due = 1;
            end else begin
                pend_cnt--;
            end
        end
        // R3: held request while stalled
        if (prev_stall) begin
            chk(mem_req_valid && mem_addr == prev_addr, "R3", "held read request",
                {2'b00, mem_addr}, {2'b00, prev_addr});
        end
        mem_req_ready = (cyc % 4) != 1;
        if (mem_req_valid && mem_req_ready) begin
            logic [29:0] want;
            want = (issued == 0) ? exp_idx : exp_idx + 30'd1;
            chk(busy && issued < exp_n, exp_tag, "unexpected bus read", issued, exp_n);
            chk(mem_addr == want, exp_tag, "bus word address", {2'b00, mem_addr}, {2'b00, want});
            issued++;
            pend     = 1;
            pend_cnt = cyc % 3;
            pend_idx = mem_addr;
        end
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr  = mem_addr;
        // Request side
        if (reqs.size() > 0 && (cyc % 7) != 3) begin
            req_valid  = 1'b1;
            req_addr   = reqs[0].addr;
            req_size   = reqs[0].size;
            req_signed = reqs[0].sgn;
            trap_mode  = reqs[0].trap;
            if (req_ready) take(reqs.pop_front());
        end else begin
            req_valid  = 1'b0;
            req_addr   = 32'hDEAD_BEEF;
            trap_mode  = 1'b1;
        end
    endtask

    task automatic add(logic [31:0] a, logic [1:0] s, logic g, logic t);
        req_t r;
        r.addr = a; r.size = s; r.sgn = g; r.trap = t;
        reqs.push_back(r);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_signed = 1'b0; trap_mode = 1'b0; mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready in reset", {31'd0, req_ready}, 32'd1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", {31'd0, mem_req_valid}, 32'd0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && rsp_valid == 1'b0, "R1",
            "state after reset", {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'h4);

        // R6 bytes, R7 signed bytes
        add(32'h40, 2'd0, 1'b0, 1'b0); add(32'h41, 2'd0, 1'b1, 1'b0);
        add(32'h42, 2'd0, 1'b0, 1'b0); add(32'h43, 2'd0, 1'b1, 1'b0);
        // halves: R4 aligned, R10 offset 1, R5 offset 3
        add(32'h40, 2'd1, 1'b0, 1'b0); add(32'h41, 2'd1, 1'b1, 1'b0);
        add(32'h42, 2'd1, 1'b1, 1'b0); add(32'h43, 2'd1, 1'b0, 1'b0);
        add(32'h47, 2'd1, 1'b1, 1'b0);
        // words: R5 crossing at each offset, R6 size code 3
        add(32'h40, 2'd2, 1'b0, 1'b0); add(32'h41, 2'd2, 1'b0, 1'b0);
        add(32'h42, 2'd2, 1'b1, 1'b0); add(32'h43, 2'd2, 1'b0, 1'b0);
        add(32'h44, 2'd3, 1'b0, 1'b0);
        // R8 faults and R9 aligned in trap mode
        add(32'h41, 2'd1, 1'b0, 1'b1); add(32'h46, 2'd2, 1'b0, 1'b1);
        add(32'h48, 2'd2, 1'b0, 1'b1); add(32'h4B, 2'd0, 1'b1, 1'b1);
        add(32'h4A, 2'd1, 1'b1, 1'b1); add(32'h4B, 2'd1, 1'b0, 1'b1);
        add(32'h4F, 2'd3, 1'b0, 1'b1);
        // R5 wrap at the top of the address space
        add(32'hFFFF_FFFE, 2'd2, 1'b0, 1'b0); add(32'hFFFF_FFFF, 2'd1, 1'b1, 1'b0);
        // Mixed sweep
        for (int i = 0; i < 24; i++) begin
            add(32'h80 + 32'(i * 5), 2'(i % 4), 1'(((i >> 0) ^ (i >> 2)) & 1), 1'(i % 5 == 0));
        end

        while ((reqs.size() > 0 || busy) && cyc < CYC_LIMIT) step();
        repeat (4) step();
        if (cyc >= CYC_LIMIT) chk(1'b0, "WATCHDOG", "run did not finish", cyc, CYC_LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule